// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block owns the protection state of a small serial EEPROM that sits behind an SPI-style command decoder. It holds the status byte: a busy flag (WIP), a write-enable latch (WEL), a two-bit block-protect field and a status-lock bit (SRWD). It also brings the active-low write-protect pin into the clock domain. For every decoded status write and every array byte write, it decides in the same cycle whether the request goes ahead or is dropped.

The decoder delivers one-cycle command strobes together with the byte address and the new status value. The block answers one clock later. It raises a grant or an ignore pulse and updates the status byte, which the decoder shifts out on a status read. Bit shifting, the nonvolatile array and the program timer sit outside the block. The program timer reports the end of a write cycle on `progDone`.

The lock is strongest when SRWD is set and the synchronised pin is low. In that state the status byte is frozen, and the block-protected part of the array can only be read. The lock can be entered in either order. The only way out is a high level on the pin.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and all four grant and ignore outputs are low.
- R2: Status byte layout: bit 0 is WIP, bit 1 is WEL, bits 3:2 are the block-protect field, bit 7 is SRWD, and bits 6:4 always read 0. A write-enable strobe sets WEL and a write-disable strobe clears it, with the change visible one cycle after the strobe.
- R3: When SRWD is 0, a status write made with WEL set is granted whatever the pin level. It loads bits 7, 3 and 2 from `srIn` and raises `srGrant` for one cycle.
- R4: When SRWD is 1 and the synchronised pin is high, a status write made with WEL set is granted.
- R5: When SRWD is 1 and the synchronised pin is low, `hwProtMode` is high. In that state every status write raises `srIgnore` and leaves bits 7:2 unchanged, even with WEL set. The mode is reached whether SRWD is set before or after the pin falls.
- R6: Driving the pin high is the only exit from the locked mode. After the pin has been high for SYNC_STAGES clocks, `hwProtMode` is low and a status write made with WEL set is granted again.
- R7: WIP and WEL keep updating in the locked mode: write enable still sets WEL, and an ignored status write still clears it.
- R8: An array write to an address inside the protected region is ignored, and WIP stays 0. The region is set by the protect field: 00 protects no addresses, 01 protects the top quarter, 10 protects the top half, and 11 protects every address. The top quarter and top half are selected by the two upper address bits.
- R9: An array write made with WEL clear is ignored. An array write to an unprotected address made with WEL set is granted and sets WIP.
- R10: WEL reads 0 one cycle after any status write or array write, whether it was granted or ignored.
- R11: A granted write sets WIP, and `progDone` clears it. While WIP is 1, every status write and every array write is ignored.
- R12: Strobes arriving together are resolved by priority: status write first, then array write, then write disable, then write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWren | input | 1 | Write-enable command strobe |
| cmdWrdi | input | 1 | Write-disable command strobe |
| cmdWrsr | input | 1 | Status-write command strobe |
| cmdWrite | input | 1 | Array-write command strobe |
| progDone | input | 1 | End of program cycle from the timer |
| addr | input | ADDR_W | Byte address of the array write |
| srIn | input | 8 | New status value for a status write |
| wpN | input | 1 | Active-low write-protect pin, asynchronous |
| statusReg | output | 8 | Status byte readback |
| srGrant | output | 1 | Status write accepted (one-cycle pulse) |
| srIgnore | output | 1 | Status write dropped (one-cycle pulse) |
| wrGrant | output | 1 | Array write accepted (one-cycle pulse) |
| wrIgnore | output | 1 | Array write dropped (one-cycle pulse) |
| hwProtMode | output | 1 | SRWD set and synchronised pin low |

## Verification
The bench builds the block with its defaults: ADDR_W of 10 for a 1024-byte array, and SYNC_STAGES of 2. With these values every byte address can be written under all four protect codes, both with the pin high and with it low, so the quarter and half boundaries are hit exactly. It also sweeps every combination of SRWD, pin level and WEL for status writes. Both orders of entering the locked mode, the exit through the pin, the busy window and simultaneous strobes are each driven on their own.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;

  // status byte bit positions (the command decoder shifts this byte out as is)
  localparam int SR_WIP  = 0;
  localparam int SR_WEL  = 1;
  localparam int SR_BP0  = 2;
  localparam int SR_BP1  = 3;
  localparam int SR_SRWD = 7;
  localparam int SR_W    = 8;

  // command selected this cycle after priority resolution
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_WRSR  = 3'd1,
    OP_WRITE = 3'd2,
    OP_WRDI  = 3'd3,
    OP_WREN  = 3'd4
  } wp_op_t;

  // strobes from control to the status datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadSr;
    logic setWip;
    logic srGrant;
    logic srIgnore;
    logic wrGrant;
    logic wrIgnore;
  } wp_strobe_t;

endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinOut
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign pinOut = pinIn;
    end else begin : g_chain
      logic [STAGES-1:0] chainQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= '1;
        else       chainQ <= {chainQ[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], pinIn} & {STAGES{1'b1}};
      end
      assign pinOut = chainQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SR_W-1:0]   statusQ,
  input  logic              wpHigh,
  output wp_strobe_t        strobe,
  output logic              hwLock
);

  localparam int TOP = ADDR_W - 1;
  localparam int NXT = ADDR_W - 2;

  wp_op_t     op;
  logic       busy;
  logic       welSet;
  logic [1:0] bpField;
  logic [1:0] upperBits;
  logic       inProt;

  // priority: status write, array write, disable, enable
  always_comb begin
    if (cmdWrsr)       op = OP_WRSR;
    else if (cmdWrite) op = OP_WRITE;
    else if (cmdWrdi)  op = OP_WRDI;
    else if (cmdWren)  op = OP_WREN;
    else               op = OP_IDLE;
  end

  assign busy      = statusQ[SR_WIP];
  assign welSet    = statusQ[SR_WEL];
  assign bpField   = {statusQ[SR_BP1], statusQ[SR_BP0]};
  assign upperBits = {addr[TOP], addr[NXT]};
  assign hwLock    = statusQ[SR_SRWD] & ~wpHigh;

  always_comb begin
    unique case (bpField)
      2'b00:   inProt = 1'b0;
      2'b01:   inProt = (upperBits == 2'b11);
      2'b10:   inProt = upperBits[1];
      default: inProt = 1'b1;
    endcase
  end

  always_comb begin
    strobe = '0;
    unique case (op)
      OP_WRSR: begin
        strobe.clrWel = 1'b1;
        if (!busy && welSet && !hwLock) begin
          strobe.loadSr  = 1'b1;
          strobe.setWip  = 1'b1;
          strobe.srGrant = 1'b1;
        end else begin
          strobe.srIgnore = 1'b1;
        end
      end
      OP_WRITE: begin
        strobe.clrWel = 1'b1;
        if (!busy && welSet && !inProt) begin
          strobe.setWip  = 1'b1;
          strobe.wrGrant = 1'b1;
        end else begin
          strobe.wrIgnore = 1'b1;
        end
      end
      OP_WRDI: strobe.clrWel = 1'b1;
      OP_WREN: strobe.setWel = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import eeprom_wp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  wp_strobe_t      strobe,
  input  logic            progDone,
  input  logic [SR_W-1:0] srIn,
  output logic [SR_W-1:0] statusQ,
  output logic            srGrant,
  output logic            srIgnore,
  output logic            wrGrant,
  output logic            wrIgnore
);

  logic       srwdQ;
  logic [1:0] bpQ;
  logic       welQ;
  logic       wipQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srwdQ <= 1'b0;
      bpQ   <= 2'b00;
    end else if (strobe.loadSr) begin
      srwdQ <= srIn[SR_SRWD];
      bpQ   <= {srIn[SR_BP1], srIn[SR_BP0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              welQ <= 1'b0;
    else if (strobe.clrWel) welQ <= 1'b0;
    else if (strobe.setWel) welQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wipQ <= 1'b0;
    else if (strobe.setWip) wipQ <= 1'b1;
    else if (progDone)      wipQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srGrant  <= 1'b0;
      srIgnore <= 1'b0;
      wrGrant  <= 1'b0;
      wrIgnore <= 1'b0;
    end else begin
      srGrant  <= strobe.srGrant;
      srIgnore <= strobe.srIgnore;
      wrGrant  <= strobe.wrGrant;
      wrIgnore <= strobe.wrIgnore;
    end
  end

  always_comb begin
    statusQ          = '0;
    statusQ[SR_WIP]  = wipQ;
    statusQ[SR_WEL]  = welQ;
    statusQ[SR_BP0]  = bpQ[0];
    statusQ[SR_BP1]  = bpQ[1];
    statusQ[SR_SRWD] = srwdQ;
  end

endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdWrite,
  input  logic              progDone,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        srIn,
  input  logic              wpN,
  output logic [7:0]        statusReg,
  output logic              srGrant,
  output logic              srIgnore,
  output logic              wrGrant,
  output logic              wrIgnore,
  output logic              hwProtMode
);

  logic       wpSync;
  wp_strobe_t strobe;
  logic [7:0] statusQ;

  wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(wpN), .pinOut(wpSync)
  );

  wp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr), .cmdWrite(cmdWrite),
    .addr(addr), .statusQ(statusQ), .wpHigh(wpSync),
    .strobe(strobe), .hwLock(hwProtMode)
  );

  wp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .progDone(progDone), .srIn(srIn),
    .statusQ(statusQ), .srGrant(srGrant), .srIgnore(srIgnore),
    .wrGrant(wrGrant), .wrIgnore(wrIgnore)
  );

  assign statusReg = statusQ;

endmodule

// File: rtl/eeprom_wp_checker.sv
module eeprom_wp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWrsr,
  input logic [7:0] statusReg,
  input logic       srGrant,
  input logic       srIgnore,
  input logic       wrGrant,
  input logic       wrIgnore,
  input logic       hwProtMode
);

  AST_HPM_SR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && hwProtMode) |=> (srIgnore && statusReg[7:2] == $past(statusReg[7:2]))); // R5

  AST_SR_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(srGrant && srIgnore)); // R3

  AST_WR_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(wrGrant && wrIgnore)); // R9

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (srGrant || wrGrant) |-> $past(statusReg[1]) && !$past(statusReg[0])); // R11

  AST_WEL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (srGrant || srIgnore || wrGrant || wrIgnore) |-> !statusReg[1]); // R10

  AST_IGNORE_NO_WIP: assert property (@(posedge clk) disable iff (!rstN)
    (srIgnore || wrIgnore) |-> !$rose(statusReg[0])); // R8

  AST_GRANT_SETS_WIP: assert property (@(posedge clk) disable iff (!rstN)
    (srGrant || wrGrant) |-> statusReg[0]); // R9

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[6:4] == 3'b000); // R2

endmodule

bind eeprom_wp_ctrl eeprom_wp_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdWrsr(cmdWrsr), .statusReg(statusReg),
  .srGrant(srGrant), .srIgnore(srIgnore), .wrGrant(wrGrant), .wrIgnore(wrIgnore),
  .hwProtMode(hwProtMode)
);

// File: tb/eeprom_wp_ctrl_bench.sv
module eeprom_wp_ctrl_bench;

  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0, cmdWrite = 0, progDone = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        srIn = '0;
  logic              wpN = 1'b1;
  logic [7:0]        statusReg;
  logic              srGrant, srIgnore, wrGrant, wrIgnore, hwProtMode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eeprom_wp_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_eeprom_wp_ctrl (
    .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .cmdWrite(cmdWrite), .progDone(progDone), .addr(addr), .srIn(srIn), .wpN(wpN),
    .statusReg(statusReg), .srGrant(srGrant), .srIgnore(srIgnore), .wrGrant(wrGrant),
    .wrIgnore(wrIgnore), .hwProtMode(hwProtMode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wren();  cmdWren = 1;  @(negedge clk); cmdWren = 0;  endtask
  task automatic wrdi();  cmdWrdi = 1;  @(negedge clk); cmdWrdi = 0;  endtask
  task automatic done();  progDone = 1; @(negedge clk); progDone = 0; endtask
  task automatic wrsr(input logic [7:0] v);
    srIn = v; cmdWrsr = 1; @(negedge clk); cmdWrsr = 0;
  endtask
  task automatic wrAt(input int a);
    addr = a[ADDR_W-1:0]; cmdWrite = 1; @(negedge clk); cmdWrite = 0;
  endtask
  task automatic setWp(input logic v);
    wpN = v; repeat (3) @(negedge clk);
  endtask

  // status byte {srwd,000,bp,0,0}, written with the pin high
  task automatic loadSr(input logic srwd, input logic [1:0] bp);
    setWp(1'b1); wren(); wrsr({srwd, 3'b000, bp, 2'b00}); done();
  endtask

  function automatic bit isProt(input int bp, input int a);
    case (bp)
      0:       return 0;
      1:       return a >= (DEPTH * 3) / 4;
      2:       return a >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(statusReg == 8'h00, "R1 status", statusReg, 8'h00);
    check({srGrant, srIgnore, wrGrant, wrIgnore} == 4'b0, "R1 flags",
          {srGrant, srIgnore, wrGrant, wrIgnore}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 WEL set and clear
    wren();
    check(statusReg == 8'h02, "R2 wren", statusReg, 8'h02);
    wrdi();
    check(statusReg == 8'h00, "R2 wrdi", statusReg, 8'h00);

    // R12 simultaneous strobes: wrdi beats wren
    wren();
    cmdWren = 1; cmdWrdi = 1; @(negedge clk); cmdWren = 0; cmdWrdi = 0;
    check(statusReg[1] == 1'b0, "R12 wrdi over wren", statusReg, 0);
    // R12 status write beats array write
    wren();
    srIn = 8'h04; addr = '0; cmdWrsr = 1; cmdWrite = 1; @(negedge clk);
    cmdWrsr = 0; cmdWrite = 0;
    check(srGrant && !wrGrant && !wrIgnore, "R12 wrsr over write",
          {srGrant, wrGrant, wrIgnore}, 3'b100);
    done();
    loadSr(1'b0, 2'b00);

    // R3 R4 R5 R7 R10 sweep over srwd, pin level and WEL
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        for (int e = 0; e < 2; e++) begin
          bit expG;
          logic [7:0] expSr;
          loadSr(1'b0, 2'b00);
          if (s == 1) loadSr(1'b1, 2'b00);
          setWp(w[0]);
          check(hwProtMode == (s == 1 && w == 0), "R5 mode flag", hwProtMode, (s == 1 && w == 0));
          if (e == 1) begin
            wren();
            check(statusReg[1] == 1'b1, "R7 wel sets", statusReg, 1);
          end
          expG  = (e == 1) && !(s == 1 && w == 0);
          wrsr(8'h7C);
          expSr = expG ? 8'h0D : {s[0], 7'b0};
          check(srGrant == expG && srIgnore == !expG, "R3 R4 R5 grant",
                {srGrant, srIgnore}, {expG, !expG});
          check(statusReg == expSr, "R10 status after wrsr", statusReg, expSr);
          if (expG) done();
        end
      end
    end

    // R5 other order: pin low first, then set SRWD
    loadSr(1'b0, 2'b00);
    setWp(1'b0);
    check(!hwProtMode, "R5 pin only", hwProtMode, 0);
    wren(); wrsr(8'h80); done();
    check(hwProtMode && statusReg == 8'h80, "R5 entered after pin", statusReg, 8'h80);
    wren(); wrsr(8'h00);
    check(srIgnore && statusReg == 8'h80, "R5 locked", statusReg, 8'h80);
    // R6 exit only by pin high
    setWp(1'b1);
    check(!hwProtMode, "R6 exit flag", hwProtMode, 0);
    wren(); wrsr(8'h00);
    check(srGrant && statusReg == 8'h01, "R6 writable again", statusReg, 8'h01);
    done();

    // R9 write without WEL
    wrAt(0);
    check(wrIgnore && statusReg[0] == 0, "R9 no wel", statusReg, 0);

    // R11 busy window
    wren(); wrAt(5);
    check(wrGrant && statusReg == 8'h01, "R11 wip set", statusReg, 8'h01);
    wren(); wrAt(6);
    check(wrIgnore && statusReg == 8'h01, "R11 write while busy", statusReg, 8'h01);
    wren(); wrsr(8'h8C);
    check(srIgnore && statusReg == 8'h01, "R11 wrsr while busy", statusReg, 8'h01);
    done();
    check(statusReg == 8'h00, "R11 progDone clears", statusReg, 8'h00);

    // R8 R9 exhaustive address sweep, every protect code, pin high and low
    for (int bp = 0; bp < 4; bp++) begin
      for (int w = 0; w < 2; w++) begin
        loadSr(1'b1, bp[1:0]);
        setWp(w[0]);
        for (int a = 0; a < DEPTH; a++) begin
          bit expG;
          expG = !isProt(bp, a);
          wren();
          wrAt(a);
          if (!(wrGrant == expG && wrIgnore == !expG && statusReg[0] == expG && !statusReg[1]))
            $display("FAIL R8 bp=%0d wp=%0d addr=%0d", bp, w, a);
          check(wrGrant == expG && wrIgnore == !expG && statusReg[0] == expG && !statusReg[1],
                "R8 array write", {wrGrant, wrIgnore, statusReg[1:0]},
                {expG, !expG, 1'b0, expG});
          if (expG) done();
        end
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule